// File: doc/BRIEF.md
# Burst Read Sequencer

This block reads a run of consecutive words out of a local storage array from a single command. A requester drives a row and a column together with a one-cycle start strobe. The block captures both into registers on that clock edge. After a fixed access latency it presents one word per clock on a registered data output, marked by a valid flag. An internal column counter begins at the captured column and steps once per word. When it passes the top of the column range it wraps within the same row. A done flag marks the final word of the run.

The storage array is filled through a separate registered write port. A test environment, or a neighbouring block, can place known contents in the array before bursts are issued. While a burst is in flight the block reports busy and ignores further start strobes, so one command always yields exactly one complete run. The defaults give 4-cycle latency, 8-word bursts of 32-bit words, 4 rows and 16 columns.

Top module: `burst_read_seq`

## Requirements
- R1: While `rst_n` is low, `rdValid`, `burstDone` and `busy` are low and `rdData` is zero. A reset asserted during a burst abandons it.
- R2: A start is accepted at a rising edge where `startIn` is high and `busy` is low. `rowIn` and `colIn` are captured at that edge. The first word is on the outputs after the LATENCY-th rising edge following the accepting edge.
- R3: Each accepted start gives exactly BURST_LEN consecutive cycles with `rdValid` high and one word per cycle. `rdData` is zero on every cycle where `rdValid` is low.
- R4: Word i of a burst (i counting from 0) is the stored word at the captured row and column (col + i) mod 2^COL_W. The column wraps inside the row and never carries into the row.
- R5: `burstDone` is high for exactly one cycle per burst, on the cycle carrying the last word.
- R6: `busy` is high from the cycle after the accepting edge through the last-word cycle, which is LATENCY + BURST_LEN cycles, and low otherwise.
- R7: A start strobe that arrives while `busy` is high is ignored. It changes neither the address nor the data of the burst in flight, and it produces no later burst.
- R8: A rising edge with `wrEn` high stores `wrData` at row `wrRow`, column `wrCol`. A burst accepted two or more edges later reads the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Start strobe for a burst |
| rowIn | input | ROW_W | Row of the burst, captured on acceptance |
| colIn | input | COL_W | First column of the burst, captured on acceptance |
| wrEn | input | 1 | Write strobe for the storage array |
| wrRow | input | ROW_W | Row written |
| wrCol | input | COL_W | Column written |
| wrData | input | DATA_W | Word written |
| rdData | output | DATA_W | Registered burst word, zero when not valid |
| rdValid | output | 1 | High on each cycle carrying a burst word |
| burstDone | output | 1 | High with the last word of a burst |
| busy | output | 1 | High while a burst is pending or in progress |

## Verification
A wrong latency count shows as `rdValid` rising one or more cycles away from the LATENCY-th edge, which the very first burst exposes. A faulty column counter appears in the data order at the first beat that differs. A carry into the row shows only on bursts that start near the top column, which is why every row and column start is swept. A beat counter or busy logic that ends early or late moves `burstDone` and the fall of `busy` within the same burst. A start strobe that is not blocked corrupts the run in flight or adds a second burst within LATENCY cycles of the end.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Strobes from the control section into the datapath
  typedef struct packed {
    logic capture;  // load row and column registers
    logic emit;     // read the addressed word and advance the column
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_BURST = 2'd2
  } seqState_t;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int LATENCY   = 4,
  parameter int BURST_LEN = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         startIn,
  output ctrlStrobes_t strobes,
  output logic         rdValid,
  output logic         burstDone,
  output logic         busy
);

  localparam int WAIT_W = (LATENCY > 2) ? $clog2(LATENCY) : 1;
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'((LATENCY > 1) ? LATENCY - 2 : 0);
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BURST_LEN - 1);

  seqState_t         state;
  logic [WAIT_W-1:0] waitCnt;
  logic [BEAT_W-1:0] beatCnt;
  logic              lastBeat;

  // The done cycle still belongs to the burst, so a start is refused there too
  always_comb begin
    strobes         = '0;
    strobes.capture = startIn && (state == SEQ_IDLE) && !burstDone;
    strobes.emit    = (state == SEQ_BURST);
    lastBeat        = strobes.emit && (beatCnt == BEAT_LAST);
  end

  assign busy = (state != SEQ_IDLE) || burstDone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      waitCnt   <= '0;
      beatCnt   <= '0;
      rdValid   <= 1'b0;
      burstDone <= 1'b0;
    end else begin
      rdValid   <= strobes.emit;
      burstDone <= lastBeat;
      case (state)
        SEQ_IDLE: begin
          if (strobes.capture) begin
            state   <= (LATENCY > 1) ? SEQ_WAIT : SEQ_BURST;
            waitCnt <= '0;
            beatCnt <= '0;
          end
        end
        SEQ_WAIT: begin
          if (waitCnt == WAIT_LAST) state <= SEQ_BURST;
          else waitCnt <= waitCnt + 1'b1;
        end
        SEQ_BURST: begin
          if (lastBeat) state <= SEQ_IDLE;
          else beatCnt <= beatCnt + 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ROW_W  = 2,
  parameter int COL_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [ROW_W-1:0]  rowIn,
  input  logic [COL_W-1:0]  colIn,
  input  logic              wrEn,
  input  logic [ROW_W-1:0]  wrRow,
  input  logic [COL_W-1:0]  wrCol,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [ROW_W-1:0]  rowReg;
  logic [COL_W-1:0]  colCnt;
  logic              wrEnReg;
  logic [ADDR_W-1:0] wrAddrReg;
  logic [DATA_W-1:0] wrDataReg;

  // Address registers and column counter; the counter wraps in COL_W bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rowReg <= '0;
      colCnt <= '0;
    end else if (strobes.capture) begin
      rowReg <= rowIn;
      colCnt <= colIn;
    end else if (strobes.emit) begin
      colCnt <= colCnt + 1'b1;
    end
  end

  // Registered write inputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrEnReg   <= 1'b0;
      wrAddrReg <= '0;
      wrDataReg <= '0;
    end else begin
      wrEnReg   <= wrEn;
      wrAddrReg <= {wrRow, wrCol};
      wrDataReg <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEnReg) store[wrAddrReg] <= wrDataReg;
  end

  // Registered data output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdData <= '0;
    else if (strobes.emit) rdData <= store[{rowReg, colCnt}];
    else rdData <= '0;
  end

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_seq_pkg::*;
#(
  parameter int ROW_W     = 2,
  parameter int COL_W     = 4,
  parameter int DATA_W    = 32,
  parameter int LATENCY   = 4,
  parameter int BURST_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startIn,
  input  logic [ROW_W-1:0]  rowIn,
  input  logic [COL_W-1:0]  colIn,
  input  logic              wrEn,
  input  logic [ROW_W-1:0]  wrRow,
  input  logic [COL_W-1:0]  wrCol,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              burstDone,
  output logic              busy
);

  ctrlStrobes_t strobes;

  burst_seq_ctrl #(
    .LATENCY   (LATENCY),
    .BURST_LEN (BURST_LEN)
  ) uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startIn   (startIn),
    .strobes   (strobes),
    .rdValid   (rdValid),
    .burstDone (burstDone),
    .busy      (busy)
  );

  burst_seq_datapath #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
  ) uData (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .rowIn   (rowIn),
    .colIn   (colIn),
    .wrEn    (wrEn),
    .wrRow   (wrRow),
    .wrCol   (wrCol),
    .wrData  (wrData),
    .rdData  (rdData)
  );

endmodule

// File: rtl/burst_read_seq_chk.sv
module burst_read_seq_chk #(
  parameter int DATA_W    = 32,
  parameter int LATENCY   = 4,
  parameter int BURST_LEN = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              startIn,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              burstDone,
  input logic              busy
);

  logic [15:0] sinceStart;
  logic [15:0] runCnt;
  logic        accepted;

  assign accepted = startIn && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sinceStart <= 16'hFFFF;
      runCnt     <= '0;
    end else begin
      if (accepted) sinceStart <= 16'd1;
      else if (sinceStart != 16'hFFFF) sinceStart <= sinceStart + 16'd1;
      if (rdValid && !burstDone) runCnt <= runCnt + 16'd1;
      else runCnt <= '0;
    end
  end

  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      AST_RESET_IDLE: assert (!rdValid && !burstDone && !busy && rdData == '0); // R1
    end
  end

  AST_START_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdValid) |-> sinceStart == 16'(LATENCY + 1)); // R2

  AST_BEAT_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid && !burstDone |=> rdValid); // R3

  AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |-> runCnt < 16'(BURST_LEN)); // R3

  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rdValid |-> rdData == '0); // R3

  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    burstDone |-> rdValid && runCnt == 16'(BURST_LEN - 1)); // R5

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    burstDone |=> !rdValid && !burstDone); // R5

  AST_BUSY_OVER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |-> busy); // R6

  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    burstDone |=> !busy); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    startIn && busy && !burstDone |=> busy); // R7

endmodule

bind burst_read_seq burst_read_seq_chk #(
  .DATA_W    (DATA_W),
  .LATENCY   (LATENCY),
  .BURST_LEN (BURST_LEN)
) uChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .startIn   (startIn),
  .rdData    (rdData),
  .rdValid   (rdValid),
  .burstDone (burstDone),
  .busy      (busy)
);

// File: tb/burst_read_seq_test.sv
module burst_read_seq_test;

  localparam int ROW_W = 2;
  localparam int COL_W = 4;
  localparam int DATA_W = 32;
  localparam int LAT = 4;
  localparam int BL = 8;
  localparam int NROW = 1 << ROW_W;
  localparam int NCOL = 1 << COL_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              startIn = 1'b0;
  logic [ROW_W-1:0]  rowIn = '0;
  logic [COL_W-1:0]  colIn = '0;
  logic              wrEn = 1'b0;
  logic [ROW_W-1:0]  wrRow = '0;
  logic [COL_W-1:0]  wrCol = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              rdValid;
  logic              burstDone;
  logic              busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [DATA_W-1:0] expMem [NROW*NCOL];

  burst_read_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .LATENCY(LAT), .BURST_LEN(BL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .startIn(startIn), .rowIn(rowIn), .colIn(colIn),
    .wrEn(wrEn), .wrRow(wrRow), .wrCol(wrCol), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .burstDone(burstDone), .busy(busy)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [DATA_W-1:0] seedWord(input int a);
    return 32'h3C6E_F372 ^ (32'(a) * 32'h0101_0101) ^ (32'(a) << 20);
  endfunction

  task automatic writeWord(input int r, input int c, input logic [DATA_W-1:0] d);
    wrEn = 1'b1; wrRow = ROW_W'(r); wrCol = COL_W'(c); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    expMem[r*NCOL + c] = d;
  endtask

  // Called at a falling edge; k counts rising edges after the accepting one
  task automatic runBurst(input int r, input int c, input int intrudeAt);
    string tag;
    tag = (intrudeAt > 0) ? "R7" : "R4";
    startIn = 1'b1; rowIn = ROW_W'(r); colIn = COL_W'(c);
    @(posedge clk);
    for (int k = 0; k <= LAT + BL; k++) begin
      bit expValid, expDone, expBusy;
      logic [DATA_W-1:0] expData;
      if (k > 0) @(posedge clk);
      @(negedge clk);
      expBusy  = (k < LAT + BL);
      expValid = (k >= LAT) && (k < LAT + BL);
      expDone  = (k == LAT + BL - 1);
      expData  = expValid ? expMem[r*NCOL + ((c + k - LAT) % NCOL)] : '0;
      check(rdValid === expValid, "R2 R3", $sformatf("valid k=%0d", k), 32'(rdValid), 32'(expValid));
      check(burstDone === expDone, "R5", $sformatf("done k=%0d", k), 32'(burstDone), 32'(expDone));
      check(busy === expBusy, "R6", $sformatf("busy k=%0d", k), 32'(busy), 32'(expBusy));
      check(rdData === expData, tag, $sformatf("data r=%0d c=%0d k=%0d", r, c, k), rdData, expData);
      if (k == 0) startIn = 1'b0;
      if (intrudeAt > 0 && k == intrudeAt) begin
        startIn = 1'b1; rowIn = ROW_W'(r + 1); colIn = COL_W'(c + 5);
      end
      if (intrudeAt > 0 && k == intrudeAt + 1) startIn = 1'b0;
    end
    startIn = 1'b0;
    if (intrudeAt > 0) begin
      for (int q = 0; q < LAT + BL; q++) begin
        @(negedge clk);
        check(!rdValid && !busy, "R7", "no extra burst", {30'd0, rdValid, busy}, '0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!rdValid && !burstDone && !busy, "R1", "outputs in reset",
          {29'd0, rdValid, burstDone, busy}, '0);
    check(rdData === '0, "R1", "data in reset", rdData, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: preload every word
    for (int a = 0; a < NROW*NCOL; a++) writeWord(a / NCOL, a % NCOL, seedWord(a));
    @(negedge clk);

    // R2 R3 R4 R5 R6: every row and every start column, back to back
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++)
        runBurst(r, c, 0);

    // R7: strobes early in the burst and on the final-word cycle
    runBurst(1, 13, 2);
    runBurst(2, 6, LAT + BL - 1);

    // R8: overwrite two words, then read them
    writeWord(3, 15, 32'hDEAD_BEEF);
    writeWord(3, 0, 32'h0BAD_F00D);
    @(negedge clk);
    runBurst(3, 12, 0);

    // R1: reset in the middle of a burst abandons it
    startIn = 1'b1; rowIn = 2'd0; colIn = 4'd0;
    @(negedge clk);
    startIn = 1'b0;
    repeat (LAT + 1) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!rdValid && !burstDone && !busy, "R1", "reset mid-burst",
          {29'd0, rdValid, burstDone, busy}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (LAT + BL) begin
      @(negedge clk);
      check(!rdValid && !busy, "R1", "burst abandoned", {30'd0, rdValid, busy}, '0);
    end
    runBurst(0, 9, 0);

    finishRun();
  end

endmodule